// File: doc/BRIEF.md
# Power-State Wakeup and Interrupt Conditioner

This block sits between the external event pins of a low-power processor system and its interrupt controller and clock sequencer. It synchronizes a fast interrupt pin, three general external interrupt pins, a slow-filtered media-change pin and a keyboard port into the system clock domain. It then produces one level interrupt request per source, each gated by its own mask bit. It also forms a single wakeup request that takes the system out of its idle or standby state.

The keyboard path has two options. The first selects whether all eight port lines or only the low six contribute to the key-pressed term; when six are used, the upper two lines are flagged as free for general-purpose use. The second lets a keypress wake the system even while the keyboard interrupt is masked. In that case execution resumes without a keyboard request.

A small sequencer tracks run, idle, standby and settle states. Idle exits at once. Standby exits through a settle count whose length, long or short, is chosen by a fast-wake bit. The sequencer drives a processor-release output.

Top module: `pwr_wake_cond`

## Requirements
- R1: After reset, `irq_req` and `wake_req` are 0, `kbd_serviced` is 0 and `cpu_release` is 1 (run state).
- R2: Pins `fiq_pin`, `ext1_pin`, `ext2_pin` and `ext3_pin` reach `irq_req` bits 0, 1, 2 and 3 two clock edges after they change, with no filtering. Each bit is ANDed with the same bit of `irq_mask`.
- R3: `irq_req[4]` (media change, gated by `irq_mask[4]`) rises only after two consecutive `slow_tick` samples of the synchronized media pin are both 1. It falls at the first tick that samples 0, so a pin that is high for only one sample is never recognized.
- R4: With `cfg_kbd_narrow`=0, the key-pressed term is the OR of all 8 `kbd_pin` lines. `irq_req[5]` equals that term ANDed with `irq_mask[5]`.
- R5: With `cfg_kbd_narrow`=1, only `kbd_pin[5:0]` are ORed and lines 7:6 have no effect on `irq_req[5]` or `wake_req`. `gpio_avail` is 2'b11 when narrow and 2'b00 otherwise.
- R6: With `cfg_kbd_direct`=0, a keypress contributes to `wake_req` only when `irq_mask[5]`=1.
- R7: With `cfg_kbd_direct`=1, a keypress drives `wake_req` whatever `irq_mask[5]` is. `irq_req[5]` and `kbd_serviced` are 1 only if `irq_mask[5]`=1; otherwise the wake is a plain resume.
- R8: `wake_req` is the OR of `irq_req[4:0]` and the keyboard wake term.
- R9: In idle, a `wake_req` sampled at a clock edge makes `cpu_release` 1 after that same edge.
- R10: In standby, a `wake_req` sampled at edge k starts a settle count of N cycles, where N = SETTLE_SHORT if `cfg_fast_wake`=1 at edge k and SETTLE_LONG otherwise. `cpu_release` stays 0 through edge k+N-1 and is 1 after edge k+N.
- R11: `enter_idle` and `enter_standby` act only in run state and drop `cpu_release` to 0 after the next edge. When both are high, standby wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fiq_pin | input | 1 | Fast interrupt pin (asynchronous) |
| ext1_pin | input | 1 | External interrupt pin 1 (asynchronous) |
| ext2_pin | input | 1 | External interrupt pin 2 (asynchronous) |
| ext3_pin | input | 1 | External interrupt pin 3 (asynchronous) |
| media_pin | input | 1 | Media-change pin (asynchronous, slow-filtered) |
| kbd_pin | input | KBD_W | Keyboard port lines (asynchronous) |
| slow_tick | input | 1 | One-cycle strobe at the 16 kHz sampling rate |
| cfg_kbd_narrow | input | 1 | 1: only the low NARROW_W keyboard lines are used |
| cfg_kbd_direct | input | 1 | 1: keypress wakes regardless of the keyboard mask |
| cfg_fast_wake | input | 1 | 1: short standby settle, 0: long |
| irq_mask | input | 6 | Per-source enable: 0 fiq, 1-3 ext1-3, 4 media, 5 keyboard |
| enter_idle | input | 1 | Strobe: enter idle |
| enter_standby | input | 1 | Strobe: enter standby |
| irq_req | output | 6 | Per-source level interrupt requests |
| wake_req | output | 1 | Wakeup request |
| kbd_serviced | output | 1 | Keyboard wake will be serviced as an interrupt |
| gpio_avail | output | KBD_W-NARROW_W | Upper keyboard lines free for GPIO |
| cpu_release | output | 1 | Processor may run |

## Verification
The hardest situation to reach is a standby exit whose settle length depends on a fast-wake bit that is sampled in one particular cycle, after a wake request that itself arrives through the two-flop synchronizer. The bench enters standby with a strobe and then raises an external pin. It counts edges through the synchronizer and the settle count, and probes `cpu_release` one edge before and one edge after the expected release, for both settle lengths and for the case where both entry strobes are high at once. A second corner is a one-sample media glitch, which directed tick sequences produce between random keyboard and mask patterns.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int NSRC      = 6;
  localparam int IDX_FIQ   = 0;
  localparam int IDX_MEDIA = 4;
  localparam int IDX_KBD   = 5;

  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,
    PS_IDLE   = 2'd1,
    PS_STBY   = 2'd2,
    PS_SETTLE = 2'd3
  } pstate_t;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/wk_media_filter.sv
module wk_media_filter #(
  parameter int TAPS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic level_in,
  output logic level_ok
);
  logic [TAPS-1:0] samp_q;

  generate
    if (TAPS == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    samp_q <= '0;
        else if (tick) samp_q <= level_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    samp_q <= '0;
        else if (tick) samp_q <= {samp_q[TAPS-2:0], level_in};
      end
    end
  endgenerate

  assign level_ok = &samp_q;
endmodule

// File: rtl/wk_kbd_path.sv
module wk_kbd_path #(
  parameter int KBD_W    = 8,
  parameter int NARROW_W = 6
) (
  input  logic [KBD_W-1:0]          keys,
  input  logic                      narrow,
  input  logic                      direct,
  input  logic                      kmask,
  output logic                      key_any,
  output logic                      key_irq,
  output logic                      key_wake,
  output logic                      key_serviced,
  output logic [KBD_W-NARROW_W-1:0] gpio_free
);
  localparam int GPIO_W = KBD_W - NARROW_W;

  function automatic logic any_key(input logic [KBD_W-1:0] k, input logic nar);
    logic [KBD_W-1:0] sel;
    sel = nar ? {{GPIO_W{1'b0}}, {NARROW_W{1'b1}}} : {KBD_W{1'b1}};
    return |(k & sel);
  endfunction

  assign key_any      = any_key(keys, narrow);
  assign key_irq      = key_any & kmask;
  assign key_wake     = key_any & (direct | kmask);
  assign key_serviced = key_wake & kmask;
  assign gpio_free    = {GPIO_W{narrow}};
endmodule

// File: rtl/wk_power_seq.sv
module wk_power_seq
  import wake_pkg::*;
#(
  parameter int SETTLE_LONG  = 2000,
  parameter int SETTLE_SHORT = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wake,
  input  logic    go_idle,
  input  logic    go_standby,
  input  logic    fast,
  output logic    release_o,
  output pstate_t state_o,
  output logic    settle_busy
);
  localparam int CW = $clog2(SETTLE_LONG + 1);

  function automatic logic [CW-1:0] settle_load(input logic f);
    return f ? CW'(SETTLE_SHORT - 1) : CW'(SETTLE_LONG - 1);
  endfunction

  pstate_t       st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_RUN;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        PS_RUN: begin
          if (go_standby)   st_q <= PS_STBY;
          else if (go_idle) st_q <= PS_IDLE;
        end
        PS_IDLE: if (wake) st_q <= PS_RUN;
        PS_STBY: begin
          if (wake) begin
            st_q  <= PS_SETTLE;
            cnt_q <= settle_load(fast);
          end
        end
        PS_SETTLE: begin
          if (cnt_q == '0) st_q  <= PS_RUN;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= PS_RUN;
      endcase
    end
  end

  assign release_o   = (st_q == PS_RUN);
  assign state_o     = st_q;
  assign settle_busy = (st_q == PS_SETTLE);
endmodule

// File: rtl/pwr_wake_cond.sv
module pwr_wake_cond
  import wake_pkg::*;
#(
  parameter int KBD_W        = 8,
  parameter int NARROW_W     = 6,
  parameter int MEDIA_TAPS   = 2,
  parameter int SETTLE_LONG  = 2000,
  parameter int SETTLE_SHORT = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fiq_pin,
  input  logic                      ext1_pin,
  input  logic                      ext2_pin,
  input  logic                      ext3_pin,
  input  logic                      media_pin,
  input  logic [KBD_W-1:0]          kbd_pin,
  input  logic                      slow_tick,
  input  logic                      cfg_kbd_narrow,
  input  logic                      cfg_kbd_direct,
  input  logic                      cfg_fast_wake,
  input  logic [5:0]                irq_mask,
  input  logic                      enter_idle,
  input  logic                      enter_standby,
  output logic [5:0]                irq_req,
  output logic                      wake_req,
  output logic                      kbd_serviced,
  output logic [KBD_W-NARROW_W-1:0] gpio_avail,
  output logic                      cpu_release
);
  localparam int NPIN = 5;
  localparam int SW   = NPIN + KBD_W;

  logic [SW-1:0]    sync_out;
  logic [NPIN-1:0]  pin_sync;
  logic [KBD_W-1:0] kbd_sync;
  logic             media_ok;
  logic             kbd_any;
  logic             kbd_irq;
  logic             kbd_wake;
  logic [IDX_MEDIA:0] cond;
  pstate_t          pstate;
  logic             settle_busy;

  wk_sync #(.W(SW)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({kbd_pin, media_pin, ext3_pin, ext2_pin, ext1_pin, fiq_pin}),
    .q_sync  (sync_out)
  );
  assign pin_sync = sync_out[NPIN-1:0];
  assign kbd_sync = sync_out[SW-1:NPIN];

  wk_media_filter #(.TAPS(MEDIA_TAPS)) u_media (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (slow_tick),
    .level_in (pin_sync[IDX_MEDIA]),
    .level_ok (media_ok)
  );

  wk_kbd_path #(.KBD_W(KBD_W), .NARROW_W(NARROW_W)) u_kbd (
    .keys         (kbd_sync),
    .narrow       (cfg_kbd_narrow),
    .direct       (cfg_kbd_direct),
    .kmask        (irq_mask[IDX_KBD]),
    .key_any      (kbd_any),
    .key_irq      (kbd_irq),
    .key_wake     (kbd_wake),
    .key_serviced (kbd_serviced),
    .gpio_free    (gpio_avail)
  );

  assign cond = {media_ok, pin_sync[IDX_MEDIA-1:IDX_FIQ]};

  generate
    for (genvar i = 0; i <= IDX_MEDIA; i++) begin : g_gate
      assign irq_req[i] = cond[i] & irq_mask[i];
    end
  endgenerate
  assign irq_req[IDX_KBD] = kbd_irq;

  assign wake_req = (|irq_req[IDX_MEDIA:0]) | kbd_wake;

  wk_power_seq #(.SETTLE_LONG(SETTLE_LONG), .SETTLE_SHORT(SETTLE_SHORT)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake        (wake_req),
    .go_idle     (enter_idle),
    .go_standby  (enter_standby),
    .fast        (cfg_fast_wake),
    .release_o   (cpu_release),
    .state_o     (pstate),
    .settle_busy (settle_busy)
  );
endmodule

// File: rtl/pwr_wake_cond_chk.sv
module pwr_wake_cond_chk
  import wake_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] irq_mask,
  input logic [5:0] irq_req,
  input logic       wake_req,
  input logic       cpu_release,
  input logic       cfg_kbd_direct,
  input logic       kbd_any,
  input logic       media_ok,
  input logic       slow_tick,
  input pstate_t    pstate,
  input logic       settle_busy
);
  p_mask_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req[3:0] & ~irq_mask[3:0]) == 4'b0);

  p_media_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(media_ok) |-> $past(slow_tick));

  p_kbd_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_kbd_direct && !irq_mask[5] && irq_req[4:0] == 5'b0) |-> !wake_req);

  p_direct_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_kbd_direct && kbd_any) |-> wake_req);

  p_idle_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == PS_IDLE && wake_req) |=> cpu_release);

  p_settle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    settle_busy |-> !cpu_release);

  p_stby_no_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == PS_STBY && !wake_req) |=> !cpu_release);
endmodule

bind pwr_wake_cond pwr_wake_cond_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .irq_mask       (irq_mask),
  .irq_req        (irq_req),
  .wake_req       (wake_req),
  .cpu_release    (cpu_release),
  .cfg_kbd_direct (cfg_kbd_direct),
  .kbd_any        (kbd_any),
  .media_ok       (media_ok),
  .slow_tick      (slow_tick),
  .pstate         (pstate),
  .settle_busy    (settle_busy)
);

// File: tb/pwr_wake_cond_bench.sv
`timescale 1ns/1ps
module pwr_wake_cond_bench;
  localparam int B_LONG  = 300;
  localparam int B_SHORT = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fiq_pin = 0, ext1_pin = 0, ext2_pin = 0, ext3_pin = 0, media_pin = 0;
  logic [7:0] kbd_pin = '0;
  logic       slow_tick = 0;
  logic       cfg_kbd_narrow = 0, cfg_kbd_direct = 0, cfg_fast_wake = 0;
  logic [5:0] irq_mask = '0;
  logic       enter_idle = 0, enter_standby = 0;
  logic [5:0] irq_req;
  logic       wake_req, kbd_serviced, cpu_release;
  logic [1:0] gpio_avail;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pwr_wake_cond #(.SETTLE_LONG(B_LONG), .SETTLE_SHORT(B_SHORT)) u_pwr_wake_cond (
    .clk(clk), .rst_n(rst_n), .fiq_pin(fiq_pin), .ext1_pin(ext1_pin),
    .ext2_pin(ext2_pin), .ext3_pin(ext3_pin), .media_pin(media_pin),
    .kbd_pin(kbd_pin), .slow_tick(slow_tick), .cfg_kbd_narrow(cfg_kbd_narrow),
    .cfg_kbd_direct(cfg_kbd_direct), .cfg_fast_wake(cfg_fast_wake),
    .irq_mask(irq_mask), .enter_idle(enter_idle), .enter_standby(enter_standby),
    .irq_req(irq_req), .wake_req(wake_req), .kbd_serviced(kbd_serviced),
    .gpio_avail(gpio_avail), .cpu_release(cpu_release)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic key_term(input logic [7:0] k, input logic nar);
    if (nar) return k[0] | k[1] | k[2] | k[3] | k[4] | k[5];
    return k != 8'h00;
  endfunction

  function automatic int settle_cycles(input logic stby, input logic fast);
    if (!stby) return 0;
    return fast ? B_SHORT : B_LONG;
  endfunction

  task automatic settle_pins(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick_once;
    @(negedge clk) slow_tick = 1'b1;
    @(negedge clk) slow_tick = 1'b0;
  endtask

  // enter a low-power state, then wake through ext1 and probe release timing
  task automatic sleep_wake(input logic want_idle, input logic want_stby, input logic fast, input string req);
    int n;
    n = settle_cycles(want_stby, fast);
    irq_mask = 6'b000010;
    @(negedge clk);
    enter_idle = want_idle;
    enter_standby = want_stby;
    @(negedge clk);
    enter_idle = 0;
    enter_standby = 0;
    chk("R11 release drops on entry", cpu_release, 0);
    settle_pins(3);
    chk("R11 stays down before wake", cpu_release, 0);
    cfg_fast_wake = fast;
    ext1_pin = 1'b1;
    settle_pins(2 + n);
    chk({req, " release one edge early"}, cpu_release, 0);
    settle_pins(1);
    chk({req, " release on time"}, cpu_release, 1);
    ext1_pin = 1'b0;
    settle_pins(3);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] k;
    logic [3:0] p;
    logic [5:0] m;
    logic nar, dir, kt, kw;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    chk("R1 irq_req reset", irq_req, 0);
    chk("R1 wake_req reset", wake_req, 0);
    chk("R1 kbd_serviced reset", kbd_serviced, 0);
    chk("R1 cpu_release reset", cpu_release, 1);
    rst_n = 1'b1;
    settle_pins(2);
    chk("R1 release after reset", cpu_release, 1);

    // R2 exact synchronizer latency
    irq_mask = 6'b000001;
    fiq_pin = 1'b1;
    settle_pins(1);
    chk("R2 fiq not yet through", irq_req[0], 0);
    settle_pins(1);
    chk("R2 fiq after two edges", irq_req[0], 1);
    chk("R8 wake from fiq", wake_req, 1);
    irq_mask = 6'b000000;
    #1;
    chk("R2 fiq masked", irq_req[0], 0);
    fiq_pin = 1'b0;
    settle_pins(3);

    // R3 media filter
    irq_mask = 6'b010000;
    media_pin = 1'b1;
    settle_pins(3);
    tick_once();
    chk("R3 one sample not enough", irq_req[4], 0);
    tick_once();
    chk("R3 two samples recognized", irq_req[4], 1);
    chk("R8 wake from media", wake_req, 1);
    media_pin = 1'b0;
    settle_pins(3);
    chk("R3 held between ticks", irq_req[4], 1);
    tick_once();
    chk("R3 drops on low sample", irq_req[4], 0);
    media_pin = 1'b1;
    settle_pins(3);
    tick_once();
    media_pin = 1'b0;
    settle_pins(3);
    tick_once();
    chk("R3 glitch rejected", irq_req[4], 0);
    tick_once();
    chk("R3 glitch still rejected", irq_req[4], 0);

    // R5 directed: only upper keys, narrow mode
    irq_mask = 6'b100000;
    cfg_kbd_narrow = 1'b1;
    kbd_pin = 8'hC0;
    settle_pins(3);
    chk("R5 upper keys ignored irq", irq_req[5], 0);
    chk("R5 upper keys ignored wake", wake_req, 0);
    chk("R5 gpio flags narrow", gpio_avail, 2'b11);
    cfg_kbd_narrow = 1'b0;
    #1;
    chk("R4 upper keys counted wide", irq_req[5], 1);
    chk("R5 gpio flags wide", gpio_avail, 2'b00);

    // R7 directed: direct wake while masked
    irq_mask = 6'b000000;
    cfg_kbd_direct = 1'b1;
    kbd_pin = 8'h01;
    settle_pins(3);
    chk("R7 direct wake masked", wake_req, 1);
    chk("R7 no irq when masked", irq_req[5], 0);
    chk("R7 not serviced", kbd_serviced, 0);
    cfg_kbd_direct = 1'b0;
    #1;
    chk("R6 no wake when masked", wake_req, 0);
    kbd_pin = 8'h00;
    settle_pins(3);

    // random mix, media held low
    for (int it = 0; it < 300; it++) begin
      p   = 4'($urandom);
      k   = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
      m   = 6'($urandom) & 6'b101111;
      nar = 1'($urandom);
      dir = 1'($urandom);
      {ext3_pin, ext2_pin, ext1_pin, fiq_pin} = p;
      kbd_pin = k;
      irq_mask = m;
      cfg_kbd_narrow = nar;
      cfg_kbd_direct = dir;
      settle_pins(3);
      kt = key_term(k, nar);
      kw = kt & (dir | m[5]);
      chk("R2 pin requests", irq_req[3:0], p & m[3:0]);
      chk(nar ? "R5 key request narrow" : "R4 key request wide", irq_req[5], kt & m[5]);
      chk(dir ? "R7 wake direct" : "R6 wake gated", wake_req, ((p & m[3:0]) != 0) | kw);
      chk("R7 serviced", kbd_serviced, kw & m[5]);
      chk("R5 gpio flags", gpio_avail, {nar, nar});
      chk("R8 media quiet", irq_req[4], 0);
      chk("R11 run keeps release", cpu_release, 1);
    end
    {ext3_pin, ext2_pin, ext1_pin, fiq_pin} = 4'b0;
    kbd_pin = 8'h00;
    cfg_kbd_direct = 0;
    cfg_kbd_narrow = 0;
    irq_mask = 6'b0;
    settle_pins(3);

    sleep_wake(1'b1, 1'b0, 1'b0, "R9 idle exit");
    sleep_wake(1'b0, 1'b1, 1'b1, "R10 short settle");
    sleep_wake(1'b0, 1'b1, 1'b0, "R10 long settle");
    sleep_wake(1'b1, 1'b1, 1'b1, "R11 standby wins");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule